// File: doc/BRIEF.md
# Shared Mailbox Pin Data Node

This cell sits behind one I/O pin and can serve as a small mailbox that several processor cores share. One core at a time writes a value into it. Every core sees the same stored value on a single shared read bus in the same cycle. A ready flag, driven out as the pin's IN signal, goes high when new data lands. It stays high until some core acknowledges it. The stored value can be 8, 16 or 32 bits wide, as the mode register selects. Byte and word values are zero-filled up to 32 bits.

The mode register also decides whether the mailbox is live at all. Mode codes 1, 2 and 3 select byte, word and long storage. They do so only when the register's DAC-off bit is set, which means the pin is not doing analog output. In every other setting the cell is a plain I/O pin. IN then comes from a small two-input logic combiner fed by the pin and its neighbour, and the output enable follows the core's direction bit. In mailbox mode the pin still drives normally, but its output enable comes from bit 6 of the mode register.

Mode register layout, 10 bits: [4:0] mode code, [5] DAC-off, [6] mailbox output enable, [9:7] combiner function.

Top module: `mailbox_node`

## Requirements
- R1: After reset the mode register holds 10'd1 (code 1 with DAC-off clear), so the cell is a plain I/O pin and the read bus is 0.
- R2: The mailbox is active only when the mode code is 1, 2 or 3 and mode bit 5 is 1. Any other code, or bit 5 at 0, gives plain I/O.
- R3: A write accepted in mailbox mode loads the read bus and sets IN high on the clock edge where it is sampled.
- R4: Code 1 keeps bits [7:0] of the written value and code 2 keeps bits [15:0], each zero-extended to 32 bits. Code 3 keeps all 32 bits.
- R5: When several cores assert write valid in one cycle, the lowest-numbered core's data is stored and the others are dropped.
- R6: In mailbox mode, IN stays high until an acknowledge from any core, which clears it at the next edge.
- R7: A write and an acknowledge in the same cycle leave IN high, holding the new data.
- R8: pin_out always equals pin_drv. pin_oe is mode bit 6 in mailbox mode and pin_dir otherwise.
- R9: In plain mode, IN is combiner(pin_in, pin_nbr) from mode bits [9:7]: 0 A, 1 A&B, 2 A|B, 3 A^B, 4 to 7 the inverses of those. Function 0 passes pin_in straight through.
- R10: Writes and acknowledges while the mailbox is inactive change neither the stored value nor the ready flag.
- R11: A mode write on cfg_we takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 10 | New mode register value |
| wr_valid | input | NCORE | Per-core write request |
| wr_data | input | NCORE*32 | Per-core write data, core i at [32*i +: 32] |
| ack | input | NCORE | Per-core acknowledge |
| rd_data | output | 32 | Stored value, shared by all readers |
| in_flag | output | 1 | IN signal: ready flag or combined pin input |
| pin_in | input | 1 | Raw pin input (A) |
| pin_nbr | input | 1 | Neighbour pin input (B) |
| pin_drv | input | 1 | Core output value for the pin |
| pin_dir | input | 1 | Core output enable for plain mode |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The hardest state to reach is a flag left set by a mailbox write, followed by a mode change away and then back. Stray writes and acknowledges made in the meantime must leave the flag and the stored value untouched. The random stimulus reaches this by changing the mode every few cycles. Mode values are drawn from a pool that mixes live mailbox settings with near-miss settings: DAC-off clear, and codes 0 and 4 or higher. Writes and acknowledges keep coming while the mode is inactive. Directed cases cover simultaneous multi-core writes and a write that coincides with an acknowledge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W   = 32;
  localparam int MODE_W   = 10;
  localparam int CODE_W   = 5;
  localparam int DACOFF_B = 5;
  localparam int OE_B     = 6;
  localparam int FN_LSB   = 7;
  localparam logic [MODE_W-1:0] MODE_RST = 10'd1;

  // code 1/2/3 with DAC off selects a mailbox width
  function automatic logic is_mailbox(input logic [MODE_W-1:0] m);
    return m[DACOFF_B] && (m[CODE_W-1:0] inside {5'd1, 5'd2, 5'd3});
  endfunction

  function automatic logic [DATA_W-1:0] size_value(input logic [CODE_W-1:0] code,
                                                   input logic [DATA_W-1:0] d);
    case (code)
      5'd1:    return {{(DATA_W-8){1'b0}}, d[7:0]};
      5'd2:    return {{(DATA_W-16){1'b0}}, d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic combine(input logic [2:0] fn, input logic a, input logic b);
    logic r;
    case (fn[1:0])
      2'd0:    r = a;
      2'd1:    r = a & b;
      2'd2:    r = a | b;
      default: r = a ^ b;
    endcase
    return fn[2] ? ~r : r;
  endfunction
endpackage

// File: rtl/mbx_mode_reg.sv
module mbx_mode_reg
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_wdata,
  output logic [MODE_W-1:0] mode_q,
  output logic              mbx_on,
  output logic              oe_bit,
  output logic [2:0]        fn_sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= MODE_RST;
    else if (cfg_we) mode_q <= cfg_wdata;
  end

  assign mbx_on = is_mailbox(mode_q);
  assign oe_bit = mode_q[OE_B];
  assign fn_sel = mode_q[FN_LSB +: 3];
endmodule

// File: rtl/mbx_arbiter.sv
module mbx_arbiter
  import mbx_pkg::*;
#(
  parameter int NCORE = 4
) (
  input  logic [NCORE-1:0]        wr_valid,
  input  logic [NCORE*DATA_W-1:0] wr_data,
  output logic [NCORE-1:0]        grant,
  output logic                    any_wr,
  output logic [DATA_W-1:0]       win_data
);
  logic [NCORE:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < NCORE; i++) begin : g_pri
    assign grant[i]     = wr_valid[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | wr_valid[i];
  end

  assign any_wr = blocked[NCORE];

  always_comb begin
    win_data = '0;
    for (int i = 0; i < NCORE; i++)
      if (grant[i]) win_data = win_data | wr_data[i*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/mbx_store.sv
module mbx_store
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mbx_on,
  input  logic [CODE_W-1:0] code,
  input  logic              any_wr,
  input  logic [DATA_W-1:0] win_data,
  input  logic              any_ack,
  output logic [DATA_W-1:0] data_q,
  output logic              flag_q
);
  logic load_ev, clear_ev;
  assign load_ev  = mbx_on & any_wr;
  assign clear_ev = mbx_on & any_ack & ~any_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      flag_q <= 1'b0;
    end else if (load_ev) begin
      data_q <= size_value(code, win_data);
      flag_q <= 1'b1;
    end else if (clear_ev) begin
      flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mailbox_node.sv
module mailbox_node
  import mbx_pkg::*;
#(
  parameter int NCORE = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [MODE_W-1:0]       cfg_wdata,
  input  logic [NCORE-1:0]        wr_valid,
  input  logic [NCORE*DATA_W-1:0] wr_data,
  input  logic [NCORE-1:0]        ack,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    in_flag,
  input  logic                    pin_in,
  input  logic                    pin_nbr,
  input  logic                    pin_drv,
  input  logic                    pin_dir,
  output logic                    pin_out,
  output logic                    pin_oe
);
  logic [MODE_W-1:0] mode_q;
  logic              mbx_on, oe_bit;
  logic [2:0]        fn_sel;
  logic [NCORE-1:0]  grant;
  logic              any_wr;
  logic [DATA_W-1:0] win_data;
  logic              flag_q;
  logic              comb_in;

  mbx_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mode_q(mode_q), .mbx_on(mbx_on), .oe_bit(oe_bit), .fn_sel(fn_sel)
  );

  mbx_arbiter #(.NCORE(NCORE)) u_arb (
    .wr_valid(wr_valid), .wr_data(wr_data),
    .grant(grant), .any_wr(any_wr), .win_data(win_data)
  );

  mbx_store u_store (
    .clk(clk), .rst_n(rst_n), .mbx_on(mbx_on), .code(mode_q[CODE_W-1:0]),
    .any_wr(any_wr), .win_data(win_data), .any_ack(|ack),
    .data_q(rd_data), .flag_q(flag_q)
  );

  assign comb_in = combine(fn_sel, pin_in, pin_nbr);
  assign in_flag = mbx_on ? flag_q : comb_in;
  assign pin_out = pin_drv;
  assign pin_oe  = mbx_on ? oe_bit : pin_dir;
endmodule

// File: rtl/mailbox_node_chk.sv
module mailbox_node_chk
  import mbx_pkg::*;
#(
  parameter int NCORE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mbx_on,
  input logic [MODE_W-1:0] mode_q,
  input logic [NCORE-1:0]  wr_valid,
  input logic [NCORE-1:0]  ack,
  input logic [NCORE-1:0]  grant,
  input logic              flag_q,
  input logic [DATA_W-1:0] rd_data,
  input logic              in_flag
);
  // R3
  write_raises_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mbx_on && |wr_valid) |=> flag_q);

  // R6
  ack_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mbx_on && |ack && !(|wr_valid)) |=> !flag_q);

  // R6
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(mbx_on && |ack)) |=> flag_q);

  // R5
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~wr_valid) == '0) && (|wr_valid == |grant));

  // R4
  byte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mbx_on && |wr_valid && mode_q[CODE_W-1:0] == 5'd1) |=> rd_data[DATA_W-1:8] == '0);

  // R10
  idle_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mbx_on |=> ($stable(rd_data) && $stable(flag_q)));

  // R2
  in_is_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mbx_on |-> in_flag == flag_q);
endmodule

bind mailbox_node mailbox_node_chk #(.NCORE(NCORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .mbx_on(mbx_on), .mode_q(mode_q),
  .wr_valid(wr_valid), .ack(ack), .grant(grant), .flag_q(flag_q),
  .rd_data(rd_data), .in_flag(in_flag)
);

// File: tb/mailbox_node_test.sv
module mailbox_node_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int MAX_CYC = 100000;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [9:0] cfg_wdata = '0;
  logic [NC-1:0] wr_valid = '0, ack = '0;
  logic [NC*32-1:0] wr_data = '0;
  logic [31:0] rd_data;
  logic in_flag, pin_in = 0, pin_nbr = 0, pin_drv = 0, pin_dir = 0, pin_out, pin_oe;

  int n_run = 0, n_fail = 0, cyc = 0;
  logic [9:0]  m_mode;
  logic [31:0] m_data;
  logic        m_flag;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  mailbox_node #(.NCORE(NC)) uut (.*);

  function automatic logic mb(input logic [9:0] m);
    return m[5] && m[4:0] >= 5'd1 && m[4:0] <= 5'd3;
  endfunction
  function automatic logic [31:0] fit(input logic [4:0] c, input logic [31:0] d);
    if (c == 5'd1) return d & 32'h0000_00FF;
    if (c == 5'd2) return d & 32'h0000_FFFF;
    return d;
  endfunction
  function automatic logic cmb(input logic [2:0] f, input logic a, input logic b);
    logic t;
    t = (f[1:0] == 0) ? a : (f[1:0] == 1) ? (a && b) : (f[1:0] == 2) ? (a || b) : (a != b);
    return f[2] ? !t : t;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic check_all();
    logic ein, eoe;
    chk(rd_data == m_data, "R3/R4/R5/R10 rd_data", rd_data, m_data);
    ein = mb(m_mode) ? m_flag : cmb(m_mode[9:7], pin_in, pin_nbr);
    chk(in_flag == ein, mb(m_mode) ? "R6/R7 in_flag" : "R9 in_flag", {31'd0, in_flag}, {31'd0, ein});
    eoe = mb(m_mode) ? m_mode[6] : pin_dir;
    chk(pin_oe == eoe, "R8 pin_oe", {31'd0, pin_oe}, {31'd0, eoe});
    chk(pin_out == pin_drv, "R8 pin_out", {31'd0, pin_out}, {31'd0, pin_drv});
  endtask

  // advance one edge with current inputs, update model, check at negedge
  task automatic step();
    int w;
    @(posedge clk);
    if (mb(m_mode)) begin
      w = -1;
      for (int i = NC-1; i >= 0; i--) if (wr_valid[i]) w = i;
      if (w >= 0) begin
        m_data = fit(m_mode[4:0], wr_data[w*32 +: 32]);
        m_flag = 1;
      end else if (|ack) m_flag = 0;
    end
    if (cfg_we) m_mode = cfg_wdata;
    @(negedge clk);
    check_all();
    cfg_we = 0; wr_valid = '0; ack = '0;
  endtask

  task automatic set_mode(input logic [9:0] m);
    cfg_we = 1; cfg_wdata = m; step();
  endtask

  task automatic wr(input int core, input logic [31:0] d);
    wr_valid[core] = 1; wr_data[core*32 +: 32] = d;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYC);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] s;
    m_mode = 10'd1; m_data = 0; m_flag = 0;
    s = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state is plain I/O, fn 0 passes pin through
    pin_in = 1; pin_dir = 1; #1;
    chk(in_flag == 1'b1, "R1 in follows pin", {31'd0, in_flag}, 32'd1);
    chk(rd_data == 0, "R1 rd_data zero", rd_data, 0);
    chk(pin_oe == 1'b1, "R1 oe from dir", {31'd0, pin_oe}, 32'd1);
    // R10: write in plain mode ignored
    wr(0, 32'hDEAD_BEEF); step();
    chk(rd_data == 0, "R10 ignored write", rd_data, 0);
    // R2/R11: DAC-off clear with code 3 is still plain
    set_mode(10'h003); wr(1, 32'h1234_5678); step();
    chk(rd_data == 0, "R2 dac on blocks mailbox", rd_data, 0);
    // R4: byte mode
    set_mode(10'h061); wr(2, 32'hAABB_CCDD); step();
    chk(rd_data == 32'h0000_00DD, "R4 byte fill", rd_data, 32'hDD);
    chk(in_flag == 1, "R3 flag set", {31'd0, in_flag}, 1);
    step();
    chk(in_flag == 1, "R6 flag held", {31'd0, in_flag}, 1);
    // R5: simultaneous writes, long mode
    set_mode(10'h023);
    wr(3, 32'h3333_3333); wr(1, 32'h1111_1111); wr(2, 32'h2222_2222); step();
    chk(rd_data == 32'h1111_1111, "R5 lowest wins", rd_data, 32'h11111111);
    ack[2] = 1; step();
    chk(in_flag == 0, "R6 ack clears", {31'd0, in_flag}, 0);
    // R7: write + ack together, word mode
    set_mode(10'h022);
    wr(0, 32'hFEDC_BA98); ack[3] = 1; step();
    chk(in_flag == 1 && rd_data == 32'h0000_BA98, "R7 write beats ack", rd_data, 32'hBA98);
    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic [9:0] pool [8];
      pool[0] = 10'h001; pool[1] = 10'h021; pool[2] = 10'h062; pool[3] = 10'h023;
      pool[4] = 10'h024; pool[5] = 10'h020; pool[6] = 10'h043; pool[7] = 10'h061;
      if ($urandom_range(0, 7) == 0) begin
        cfg_we = 1;
        cfg_wdata = pool[$urandom_range(0, 7)];
        cfg_wdata[9:7] = 3'($urandom_range(0, 7));
      end
      for (int i = 0; i < NC; i++) begin
        wr_valid[i] = ($urandom_range(0, 5) == 0);
        ack[i]      = ($urandom_range(0, 7) == 0);
        wr_data[i*32 +: 32] = $urandom;
      end
      pin_in = 1'($urandom); pin_nbr = 1'($urandom);
      pin_drv = 1'($urandom); pin_dir = 1'($urandom);
      step();
    end
    finish_run();
  end
endmodule